// File: doc/BRIEF.md
# Speculative and Committed Store Queue

This block keeps the stores of an out-of-order core in one circular structure from the moment they are decoded until their data reaches the data cache. A slot is reserved in program order when a store enters the front end. When the store executes, its address and data are recorded in that slot. Nothing reaches the cache at that point. At retirement, up to three adjacent stores are marked committed in one cycle. Committed stores then leave through a single cache write port, oldest first, one per accepted handshake.

Speculative and committed-but-unwritten stores share the same slots. Three pointers, each with one extra wrap bit, split the ring into regions. The drain pointer marks the oldest unwritten store. The commit pointer marks the boundary between committed and speculative stores. The allocation pointer marks the next free slot. A pipeline flush moves the allocation pointer back to the commit boundary, so speculative stores are discarded and committed stores stay in the queue until they are written. A barrier request is reported complete once no committed store is waiting.

Top module: `store_queue`

## Requirements
- R1: When `alloc_req` is high and `alloc_gnt` is high, a slot is reserved. Slot indices are handed out in sequence: `alloc_idx` shows the next index, and it advances by one modulo DEPTH after each grant. With DEPTH slots occupied, `alloc_gnt` is low and no slot is reserved.
- R2: An `exe_vld` pulse records `exe_addr` and `exe_data` in slot `exe_idx` and marks that slot executed. An executed store that is not committed never raises `wr_vld`.
- R3: `cmt_cnt`, read as an unsigned count from 0 to 3, commits that many adjacent stores starting at the commit boundary, all in one cycle.
- R4: `wr_vld` is high exactly when a committed, unwritten store exists. `wr_addr` and `wr_data` show the oldest such store. While `wr_rdy` is low they hold steady. At most one store leaves per cycle, and only when `wr_vld` and `wr_rdy` are both high.
- R5: A slot becomes free only in the cycle after its write handshake. Committed but unwritten stores keep `alloc_gnt` low when the queue is full.
- R6: A `flush` pulse discards every uncommitted store. The next `alloc_idx` equals the slot just after the last committed store. Committed stores remain and are still written in order.
- R7: `fence_done` is high only while `fence_req` is high and no committed store is waiting to be written.
- R8: When `cmt_cnt` exceeds the number of adjacent executed, uncommitted stores at the commit boundary, `cmt_err` is raised in that cycle and the whole commit is ignored.
- R9: After reset the queue is empty: `alloc_gnt` is 1, `alloc_idx` is 0, `wr_vld` is 0, and `cmt_err` is 0 while `cmt_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Front end asks for a slot |
| alloc_gnt | output | 1 | A slot can be reserved this cycle; low stalls the front end |
| alloc_idx | output | IW | Index of the slot reserved on a grant |
| exe_vld | input | 1 | A store has executed |
| exe_idx | input | IW | Slot of the executed store |
| exe_addr | input | AW | Store address |
| exe_data | input | DW | Store data |
| cmt_cnt | input | CW | Number of stores retired this cycle (0 to 3) |
| cmt_err | output | 1 | Commit request exceeds the executed stores available |
| flush | input | 1 | Discard all uncommitted stores |
| fence_req | input | 1 | Barrier waiting for committed stores to drain |
| fence_done | output | 1 | Barrier may complete |
| wr_vld | output | 1 | Cache write request |
| wr_addr | output | AW | Cache write address |
| wr_data | output | DW | Cache write data |
| wr_rdy | input | 1 | Cache accepts the write |

## Verification
The assertions check these properties on every cycle:
- occupancy never exceeds DEPTH;
- the commit boundary stays inside the occupied region;
- the store offered to the cache has executed;
- the drain pointer moves only on a handshake;
- a stalled write keeps its address and data;
- the allocation pointer is frozen when full;
- a flush lands the allocation pointer on the commit boundary;
- a rejected commit leaves the boundary unchanged.

Only the bench scenarios can show the end-to-end behaviour. They check that the written addresses and data match program order across commit bursts of every size, that partially executed groups are refused, and that a flush in a full or mixed queue preserves exactly the committed stores. They also check that a freed slot is granted again only after its write.

// File: rtl/sq_pkg.sv
package sq_pkg;
   localparam int SQ_DEF_DEPTH = 8;
   localparam int SQ_DEF_AW    = 32;
   localparam int SQ_DEF_DW    = 32;
   localparam int SQ_DEF_BURST = 3;
endpackage

// File: rtl/sq_ptr.sv
module sq_ptr #(
   parameter int PW = 4
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [PW-1:0] load_val,
   input  logic [PW-1:0] step,
   output logic [PW-1:0] ptr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= load_val;
      else           ptr_q <= ptr_q + step;
   end
endmodule

// File: rtl/sq_store_array.sv
module sq_store_array #(
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int DW    = 32,
   localparam int IW   = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_we,
   input  logic [IW-1:0]    alloc_slot,
   input  logic             exe_we,
   input  logic [IW-1:0]    exe_slot,
   input  logic [AW-1:0]    exe_addr,
   input  logic [DW-1:0]    exe_data,
   input  logic [IW-1:0]    rd_slot,
   output logic [AW-1:0]    rd_addr,
   output logic [DW-1:0]    rd_data,
   output logic [DEPTH-1:0] exec_vec
);
   logic [AW-1:0] addr_mem [DEPTH];
   logic [DW-1:0] data_mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            exec_vec[i] <= 1'b0;
            addr_mem[i] <= '0;
            data_mem[i] <= '0;
         end else if (exe_we && exe_slot == IW'(i)) begin
            exec_vec[i] <= 1'b1;
            addr_mem[i] <= exe_addr;
            data_mem[i] <= exe_data;
         end else if (alloc_we && alloc_slot == IW'(i)) begin
            exec_vec[i] <= 1'b0;
         end
      end
   end

   assign rd_addr = addr_mem[rd_slot];
   assign rd_data = data_mem[rd_slot];
endmodule

// File: rtl/sq_commit_chk.sv
module sq_commit_chk #(
   parameter int DEPTH = 8,
   parameter int MAXC  = 3,
   localparam int IW   = $clog2(DEPTH),
   localparam int PW   = IW + 1,
   localparam int CW   = $clog2(MAXC + 1)
)(
   input  logic [DEPTH-1:0] exec_vec,
   input  logic [PW-1:0]    cmt_ptr,
   input  logic [PW-1:0]    tail_ptr,
   input  logic [CW-1:0]    cmt_cnt,
   output logic             cmt_err,
   output logic [CW-1:0]    cmt_adv
);
   logic [PW-1:0]   pend;
   logic [MAXC-1:0] ready_k;
   logic [CW-1:0]   avail;
   logic [IW-1:0]   slot_k [MAXC];

   assign pend = tail_ptr - cmt_ptr;

   for (genvar k = 0; k < MAXC; k++) begin : g_look
      assign slot_k[k]  = cmt_ptr[IW-1:0] + IW'(k);
      assign ready_k[k] = (pend > PW'(k)) && exec_vec[slot_k[k]];
   end

   always_comb begin
      logic run;
      run   = 1'b1;
      avail = '0;
      for (int k = 0; k < MAXC; k++) begin
         run = run && ready_k[k];
         if (run) avail = avail + CW'(1);
      end
   end

   assign cmt_err = (cmt_cnt > avail);
   assign cmt_adv = cmt_err ? '0 : cmt_cnt;
endmodule

// File: rtl/store_queue.sv
module store_queue import sq_pkg::*; #(
   parameter int DEPTH = SQ_DEF_DEPTH,
   parameter int AW    = SQ_DEF_AW,
   parameter int DW    = SQ_DEF_DW,
   parameter int MAXC  = SQ_DEF_BURST,
   localparam int IW   = $clog2(DEPTH),
   localparam int CW   = $clog2(MAXC + 1)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_req,
   output logic          alloc_gnt,
   output logic [IW-1:0] alloc_idx,
   input  logic          exe_vld,
   input  logic [IW-1:0] exe_idx,
   input  logic [AW-1:0] exe_addr,
   input  logic [DW-1:0] exe_data,
   input  logic [CW-1:0] cmt_cnt,
   output logic          cmt_err,
   input  logic          flush,
   input  logic          fence_req,
   output logic          fence_done,
   output logic          wr_vld,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   input  logic          wr_rdy
);
   localparam int PW = IW + 1;

   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("store_queue: DEPTH must be a power of two, at least 2");
   end
   if ((MAXC < 1) || (MAXC > DEPTH)) begin : g_bad_burst
      $error("store_queue: MAXC must lie in 1..DEPTH");
   end

   logic [PW-1:0]    head_q, cmt_q, tail_q, occ, pend, cmt_nxt;
   logic             full, alloc_fire, exe_fire, wr_fire;
   logic [CW-1:0]    cmt_adv;
   logic [DEPTH-1:0] exec_vec;
   logic [IW-1:0]    exe_dist;

   assign occ        = tail_q - head_q;
   assign pend       = tail_q - cmt_q;
   assign full       = (occ == PW'(DEPTH));
   assign alloc_gnt  = !full && !flush;
   assign alloc_fire = alloc_req && alloc_gnt;
   assign alloc_idx  = tail_q[IW-1:0];

   assign exe_dist   = exe_idx - cmt_q[IW-1:0];
   assign exe_fire   = exe_vld && !flush && ({1'b0, exe_dist} < pend);

   assign wr_vld     = (cmt_q != head_q);
   assign wr_fire    = wr_vld && wr_rdy;
   assign cmt_nxt    = cmt_q + PW'(cmt_adv);
   assign fence_done = fence_req && (cmt_q == head_q);

   sq_ptr #(.PW(PW)) u_head (
      .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
      .step(PW'(wr_fire)), .ptr_q(head_q));

   sq_ptr #(.PW(PW)) u_cmt (
      .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
      .step(PW'(cmt_adv)), .ptr_q(cmt_q));

   sq_ptr #(.PW(PW)) u_tail (
      .clk(clk), .rst_n(rst_n), .load(flush), .load_val(cmt_nxt),
      .step(PW'(alloc_fire)), .ptr_q(tail_q));

   sq_commit_chk #(.DEPTH(DEPTH), .MAXC(MAXC)) u_cmt_chk (
      .exec_vec(exec_vec), .cmt_ptr(cmt_q), .tail_ptr(tail_q),
      .cmt_cnt(cmt_cnt), .cmt_err(cmt_err), .cmt_adv(cmt_adv));

   sq_store_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_array (
      .clk(clk), .rst_n(rst_n),
      .alloc_we(alloc_fire), .alloc_slot(tail_q[IW-1:0]),
      .exe_we(exe_fire), .exe_slot(exe_idx),
      .exe_addr(exe_addr), .exe_data(exe_data),
      .rd_slot(head_q[IW-1:0]), .rd_addr(wr_addr), .rd_data(wr_data),
      .exec_vec(exec_vec));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH)); // R1
   AST_CMT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_q - head_q) <= occ); // R3
   AST_WR_EXECUTED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld |-> exec_vec[head_q[IW-1:0]]); // R2
   AST_HEAD_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_vld && wr_rdy) |=> $stable(head_q)); // R4
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vld && !wr_rdy) |=> (wr_vld && $stable(wr_addr) && $stable(wr_data))); // R4
   AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !flush) |=> $stable(tail_q)); // R5
   AST_FLUSH_TO_CMT: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tail_q == cmt_q)); // R6
   AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_err |=> $stable(cmt_q)); // R8
endmodule

// File: tb/store_queue_tb.sv
module store_queue_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        alloc_req, alloc_gnt;
   logic [2:0]  alloc_idx;
   logic        exe_vld;
   logic [2:0]  exe_idx;
   logic [31:0] exe_addr, exe_data;
   logic [1:0]  cmt_cnt;
   logic        cmt_err, flush, fence_req, fence_done;
   logic        wr_vld, wr_rdy;
   logic [31:0] wr_addr, wr_data;

   int checks = 0;
   int errors = 0;
   int exp_tail = 0;
   int tag = 0;

   always #4 clk = ~clk;

   store_queue u_dut (
      .clk(clk), .rst_n(rst_n),
      .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
      .exe_vld(exe_vld), .exe_idx(exe_idx), .exe_addr(exe_addr), .exe_data(exe_data),
      .cmt_cnt(cmt_cnt), .cmt_err(cmt_err), .flush(flush),
      .fence_req(fence_req), .fence_done(fence_done),
      .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .wr_rdy(wr_rdy));

   // row: [4:3] stores, [2:1] commit count, [0] expected rejection
   localparam int NROW = 8;
   localparam logic [4:0] VEC [NROW] = '{
      5'b01_01_0, 5'b10_10_0, 5'b11_11_0, 5'b11_10_0,
      5'b10_11_1, 5'b01_00_0, 5'b11_01_0, 5'b00_01_1 };

   function automatic logic [31:0] addr_of(input int t);
      return 32'h0000_1000 + 32'(t) * 4;
   endfunction
   function automatic logic [31:0] data_of(input int t);
      return 32'hD000_0000 + 32'(t);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_alloc(input int n);
      for (int k = 0; k < n; k++) begin
         alloc_req = 1'b1;
         #1;
         chk("R1 grant", 32'(alloc_gnt), 32'd1);
         chk("R1 index", 32'(alloc_idx), 32'(exp_tail % 8));
         tick();
         exp_tail++;
      end
      alloc_req = 1'b0;
   endtask

   task automatic do_exec(input int first, input int n, input int t0);
      for (int k = 0; k < n; k++) begin
         exe_vld  = 1'b1;
         exe_idx  = 3'((first + k) % 8);
         exe_addr = addr_of(t0 + k);
         exe_data = data_of(t0 + k);
         tick();
      end
      exe_vld = 1'b0;
   endtask

   task automatic do_cmt(input int c, input logic experr, input string req);
      cmt_cnt = 2'(c);
      #1;
      chk(req, 32'(cmt_err), 32'(experr));
      tick();
      cmt_cnt = 2'd0;
   endtask

   task automatic do_drain(input int n, input int t0);
      wr_rdy = 1'b1;
      for (int j = 0; j < n; j++) begin
         #1;
         chk("R4 valid", 32'(wr_vld), 32'd1);
         chk("R4 addr", wr_addr, addr_of(t0 + j));
         chk("R4 data", wr_data, data_of(t0 + j));
         tick();
      end
      wr_rdy = 1'b0;
      #1;
      chk("R4 empty", 32'(wr_vld), 32'd0);
      tick();
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; alloc_req = 1'b0; exe_vld = 1'b0; exe_idx = '0;
      exe_addr = '0; exe_data = '0; cmt_cnt = '0; flush = 1'b0;
      fence_req = 1'b0; wr_rdy = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      fence_req = 1'b1;
      #1;
      // R9 reset state, R7 fence on empty queue
      chk("R9 grant", 32'(alloc_gnt), 32'd1);
      chk("R9 index", 32'(alloc_idx), 32'd0);
      chk("R9 wr_vld", 32'(wr_vld), 32'd0);
      chk("R9 cmt_err", 32'(cmt_err), 32'd0);
      chk("R7 fence empty", 32'(fence_done), 32'd1);
      tick();
      fence_req = 1'b0;

      // table of commit bursts (R3, R8, R2, R6)
      for (int r = 0; r < NROW; r++) begin
         int n, c, first, done_n;
         logic experr;
         n = int'(VEC[r][4:3]); c = int'(VEC[r][2:1]); experr = VEC[r][0];
         first = exp_tail % 8;
         do_alloc(n);
         do_exec(first, n, tag);
         #1;
         chk("R2 no write before commit", 32'(wr_vld), 32'd0);
         do_cmt(c, experr, experr ? "R8 reject" : "R3 burst");
         done_n = experr ? 0 : c;
         do_drain(done_n, tag);
         if (n - done_n > 0) begin
            flush = 1'b1;
            tick();
            flush = 1'b0;
            exp_tail = exp_tail - (n - done_n);
         end
         tag += n;
      end

      // full queue, commit bursts, flush keeps committed, stall and release
      begin
         int first;
         first = exp_tail % 8;
         do_alloc(8);
         alloc_req = 1'b1;
         #1;
         chk("R1 full stall", 32'(alloc_gnt), 32'd0);
         tick();
         alloc_req = 1'b0;
         do_exec(first, 8, tag);
         do_cmt(3, 1'b0, "R3 burst3");
         do_cmt(3, 1'b0, "R3 burst3b");
         do_cmt(2, 1'b0, "R3 burst2");
         fence_req = 1'b1;
         #1;
         chk("R5 committed occupy", 32'(alloc_gnt), 32'd0);
         chk("R7 fence pending", 32'(fence_done), 32'd0);
         tick();
         flush = 1'b1;
         tick();
         flush = 1'b0;
         #1;
         chk("R6 committed kept", 32'(wr_vld), 32'd1);
         chk("R6 oldest kept", wr_addr, addr_of(tag));
         chk("R6 still full", 32'(alloc_gnt), 32'd0);
         tick(); tick();
         #1;
         chk("R4 hold addr", wr_addr, addr_of(tag));
         chk("R4 hold data", wr_data, data_of(tag));
         wr_rdy = 1'b1;
         tick();
         wr_rdy = 1'b0;
         #1;
         chk("R5 freed after write", 32'(alloc_gnt), 32'd1);
         chk("R4 next oldest", wr_addr, addr_of(tag + 1));
         tick();
         do_drain(7, tag + 1);
         #1;
         chk("R7 fence drained", 32'(fence_done), 32'd1);
         tick();
         fence_req = 1'b0;
         tag += 8;
      end

      // leading store not executed: rejected
      begin
         int first;
         first = exp_tail % 8;
         do_alloc(2);
         do_exec((first + 1) % 8, 1, tag + 1);
         do_cmt(1, 1'b1, "R8 leading unexecuted");
         #1;
         chk("R8 ignored", 32'(wr_vld), 32'd0);
         do_exec(first, 1, tag);
         do_cmt(2, 1'b0, "R3 pair");
         do_drain(2, tag);
         tag += 2;
      end

      // mixed flush: one committed, two discarded
      begin
         int first;
         first = exp_tail % 8;
         do_alloc(3);
         do_exec(first, 3, tag);
         do_cmt(1, 1'b0, "R3 single");
         flush = 1'b1;
         tick();
         flush = 1'b0;
         exp_tail = exp_tail - 2;
         #1;
         chk("R6 tail rewound", 32'(alloc_idx), 32'(exp_tail % 8));
         do_drain(1, tag);
         tag += 3;
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule